// File: doc/BRIEF.md
# Dual-Core Boot Mode Controller

This block decides, once per reset, how a two-core processor subsystem comes up. While reset is held it samples a set of strap pins: an external-interface select, a host bus format pin, a subsystem select pin and one ROM-enable pin per core. From these it chooses between host-port mode and external-interface mode. Pin changes after reset has been released do not affect that choice.

In host-port mode both cores stay in reset and all program RAM is visible. An external host loads memory through the host port and then starts the cores by writing to word address 002Fh. The same write clears each core's ROM-enable bit. In external-interface mode the cores leave reset one cycle after system reset ends and fetch from the boot vector 0FF80h. The fetch goes to on-chip ROM or to external memory, depending on that core's ROM-enable pin. The subsystem select pin then becomes an output that drives the top program address bit.

Each core has an 8-bit control register. Its bit 7 is the ROM-enable flag, which decides whether the 8K-word program window 0E000h to 0FFFFh maps to boot ROM or to RAM. Software can only clear that flag, which gives the window back to RAM.

Top module: `boot_mode_ctrl`

## Requirements
- R1: The strap pins are captured at the last rising clock edge where `rst_n` is low. `ext_mode`, `host_nomux` and `host_slave_en` then keep those values until the next reset, whatever the pins do.
- R2: When `ext_sel_pin` was 0 at reset (host-port mode), `ext_mode` is 0, `core_rst_n` stays 2'b00, `rom_mapped` is 2'b00 and every `boot_src` field reads 2'b00 (host-loaded RAM).
- R3: In host-port mode, a host write (`host_we` high) to address 16'h002F sets both `core_rst_n` bits from the next rising edge onward, and clears bit 7 of both control registers on that same edge.
- R4: A host write to any other address does not change `core_rst_n` or `ctl_reg`. A write to 16'h002F after the cores have been released has no effect. Any host write in external-interface mode has no effect.
- R5: At reset, bits 6:0 of each control register are set to 0. Bit 7 is set to 1 in host-port mode, and in external-interface mode it takes that core's `rom_on_pin` value. Core c's register is `ctl_reg[8c+7:8c]`.
- R6: In external-interface mode, `core_rst_n` is 0 in the first cycle after reset and all ones from the next rising edge. Each core's `boot_vec` field is 19'h0FF80. Each `boot_src` field is 2'b01 (ROM) if the core's `rom_on_pin` was 1 at reset and 2'b10 (external) if it was 0, and it does not change when software later clears bit 7.
- R7: `rom_mapped[c]` is 1 only in external-interface mode with bit 7 of core c's register set. For a core address in 19'h0E000 to 19'h0FFFF, `rom_sel[c]` equals `rom_mapped[c]` and `ram_sel[c]` is its inverse. Outside that range both are 0.
- R8: A CPU write (`cpu_we[c]`) loads bits 6:0 of core c's register from `cpu_wdata[8c+6:8c]`. Bit 7 becomes the AND of its old value and the written bit 7, so a CPU write can clear it but never set it.
- R9: In host-port mode, `host_nomux` equals the captured bus format pin. `host_slave_en` is one-hot, with bit 0 set when `subsys_pin_i` was 0 and bit 1 set when it was 1. In external-interface mode `host_slave_en` is 2'b00.
- R10: In external-interface mode `subsys_pin_oe` is 1 and `subsys_pin_o` follows `ext_addr_msb`. In host-port mode `subsys_pin_oe` and `subsys_pin_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low; straps are sampled while it is low |
| ext_sel_pin | input | 1 | Strap: 1 selects external-interface mode, 0 selects host-port mode |
| host_nomux_pin | input | 1 | Strap: host bus format, 1 for separate address and data, 0 for multiplexed |
| subsys_pin_i | input | 1 | Subsystem select pin, sampled as a strap |
| rom_on_pin | input | 2 | Per-core ROM-enable strap |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 16 | Host write address |
| cpu_we | input | 2 | Per-core control register write strobe |
| cpu_wdata | input | 16 | Per-core control register write data, 8 bits per core |
| core_paddr | input | 38 | Per-core program address, 19 bits per core |
| ext_addr_msb | input | 1 | Bit 18 of the external program address |
| ext_mode | output | 1 | Captured mode: 1 for external-interface mode |
| host_nomux | output | 1 | Captured host bus format |
| host_slave_en | output | 2 | One-hot choice of the subsystem that answers the host |
| core_rst_n | output | 2 | Per-core reset, active low |
| ctl_reg | output | 16 | Per-core control registers, 8 bits per core |
| rom_mapped | output | 2 | Per-core: the ROM owns the top 8K program window |
| boot_src | output | 4 | Per-core boot source, 2 bits per core |
| boot_vec | output | 38 | Per-core start address, 19 bits per core |
| rom_sel | output | 2 | Per-core: the current program address hits ROM |
| ram_sel | output | 2 | Per-core: the current program address hits the window RAM |
| subsys_pin_oe | output | 1 | Output enable for the subsystem select pin |
| subsys_pin_o | output | 1 | Output value for the subsystem select pin |

## Verification
Most faults in this block stay in state until the next reset. A mis-captured strap shows up at once, in the first cycle after reset, on `ext_mode`, `host_slave_en` or `core_rst_n`. A stuck release flag shows up one edge after the qualifying host write, when `core_rst_n` fails to rise. A wrong ROM-enable bit appears on `rom_mapped`, and combinationally on `rom_sel` and `ram_sel`, as soon as a core addresses the top window. That bit can only fall, so a wrongly set flag is caught only by a check made before software clears it.

// File: rtl/boot_ctl_pkg.sv
package boot_ctl_pkg;

    typedef enum logic [1:0] {
        SRC_HOST_RAM = 2'b00,
        SRC_ROM      = 2'b01,
        SRC_EXT      = 2'b10
    } boot_src_e;

    localparam int unsigned CTL_W       = 8;
    localparam int unsigned CTL_ROM_BIT = 7;

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
    parameter int unsigned          N_CORES = 2,
    parameter int unsigned          HA_W    = 16,
    parameter logic [HA_W-1:0]      REL_ADDR = 16'h002F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_sel_pin,
    input  logic               host_nomux_pin,
    input  logic               subsys_pin_i,
    input  logic [N_CORES-1:0] rom_on_pin,
    input  logic               host_we,
    input  logic [HA_W-1:0]    host_addr,
    output logic               ext_q,
    output logic               nomux_q,
    output logic               sub_b_q,
    output logic [N_CORES-1:0] rom_on_q,
    output logic               released_q,
    output logic               release_evt
);

    typedef struct packed {
        logic               ext;
        logic               nomux;
        logic               sub_b;
        logic [N_CORES-1:0] rom_on;
        logic               released;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        release_evt = rst_n && !st_q.ext && !st_q.released &&
                      host_we && (host_addr == REL_ADDR);
        st_d = st_q;
        if (!rst_n) begin
            st_d.ext      = ext_sel_pin;
            st_d.nomux    = host_nomux_pin;
            st_d.sub_b    = subsys_pin_i;
            st_d.rom_on   = rom_on_pin;
            st_d.released = 1'b0;
        end else if (st_q.ext) begin
            st_d.released = 1'b1;
        end else if (release_evt) begin
            st_d.released = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ext_q      = st_q.ext;
    assign nomux_q    = st_q.nomux;
    assign sub_b_q    = st_q.sub_b;
    assign rom_on_q   = st_q.rom_on;
    assign released_q = st_q.released;

endmodule

// File: rtl/boot_ctl_reg.sv
module boot_ctl_reg
    import boot_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel_pin,
    input  logic             rom_on_pin,
    input  logic             rom_clr,
    input  logic             cpu_we,
    input  logic [CTL_W-1:0] cpu_wdata,
    output logic [CTL_W-1:0] ctl_q
);

    localparam logic [CTL_W-1:0] ROM_MASK = CTL_W'(1) << CTL_ROM_BIT;

    logic [CTL_W-1:0] ctl_d, ctl_r_q;

    always_comb begin
        ctl_d = ctl_r_q;
        if (!rst_n) begin
            ctl_d              = '0;
            ctl_d[CTL_ROM_BIT] = ext_sel_pin ? rom_on_pin : 1'b1;
        end else begin
            if (rom_clr) begin
                ctl_d = ctl_d & ~ROM_MASK;
            end
            if (cpu_we) begin
                // flag may only fall: AND the written bit with the held one
                ctl_d = (cpu_wdata & ~ROM_MASK) | (ctl_d & cpu_wdata & ROM_MASK);
            end
        end
    end

    always_ff @(posedge clk) begin
        ctl_r_q <= ctl_d;
    end

    assign ctl_q = ctl_r_q;

endmodule

// File: rtl/boot_region_dec.sv
module boot_region_dec #(
    parameter int unsigned         PADDR_W   = 19,
    parameter logic [PADDR_W-1:0]  WIN_BASE  = 19'h0E000,
    parameter int unsigned         WIN_WORDS = 8192
) (
    input  logic [PADDR_W-1:0] paddr,
    input  logic               rom_mapped,
    output logic               rom_sel,
    output logic               ram_sel
);

    localparam logic [PADDR_W-1:0] WIN_LAST = WIN_BASE + PADDR_W'(WIN_WORDS - 1);

    logic in_win;

    always_comb begin
        in_win  = (paddr >= WIN_BASE) && (paddr <= WIN_LAST);
        rom_sel = in_win &&  rom_mapped;
        ram_sel = in_win && !rom_mapped;
    end

endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
    import boot_ctl_pkg::*;
#(
    parameter int unsigned         N_CORES   = 2,
    parameter int unsigned         PADDR_W   = 19,
    parameter int unsigned         HA_W      = 16,
    parameter logic [HA_W-1:0]     REL_ADDR  = 16'h002F,
    parameter logic [PADDR_W-1:0]  BOOT_VEC  = 19'h0FF80,
    parameter logic [PADDR_W-1:0]  WIN_BASE  = 19'h0E000,
    parameter int unsigned         WIN_WORDS = 8192
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ext_sel_pin,
    input  logic                         host_nomux_pin,
    input  logic                         subsys_pin_i,
    input  logic [N_CORES-1:0]           rom_on_pin,
    input  logic                         host_we,
    input  logic [HA_W-1:0]              host_addr,
    input  logic [N_CORES-1:0]           cpu_we,
    input  logic [N_CORES*CTL_W-1:0]     cpu_wdata,
    input  logic [N_CORES*PADDR_W-1:0]   core_paddr,
    input  logic                         ext_addr_msb,
    output logic                         ext_mode,
    output logic                         host_nomux,
    output logic [N_CORES-1:0]           host_slave_en,
    output logic [N_CORES-1:0]           core_rst_n,
    output logic [N_CORES*CTL_W-1:0]     ctl_reg,
    output logic [N_CORES-1:0]           rom_mapped,
    output logic [N_CORES*2-1:0]         boot_src,
    output logic [N_CORES*PADDR_W-1:0]   boot_vec,
    output logic [N_CORES-1:0]           rom_sel,
    output logic [N_CORES-1:0]           ram_sel,
    output logic                         subsys_pin_oe,
    output logic                         subsys_pin_o
);

    logic               ext_q, nomux_q, sub_b_q, released_q, release_evt;
    logic [N_CORES-1:0] rom_on_q;

    boot_strap_latch #(
        .N_CORES  (N_CORES),
        .HA_W     (HA_W),
        .REL_ADDR (REL_ADDR)
    ) u_strap (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_sel_pin    (ext_sel_pin),
        .host_nomux_pin (host_nomux_pin),
        .subsys_pin_i   (subsys_pin_i),
        .rom_on_pin     (rom_on_pin),
        .host_we        (host_we),
        .host_addr      (host_addr),
        .ext_q          (ext_q),
        .nomux_q        (nomux_q),
        .sub_b_q        (sub_b_q),
        .rom_on_q       (rom_on_q),
        .released_q     (released_q),
        .release_evt    (release_evt)
    );

    assign ext_mode      = ext_q;
    assign host_nomux    = nomux_q;
    assign subsys_pin_oe = ext_q;
    assign subsys_pin_o  = ext_q & ext_addr_msb;

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        logic [CTL_W-1:0] ctl_c;

        boot_ctl_reg u_ctl (
            .clk         (clk),
            .rst_n       (rst_n),
            .ext_sel_pin (ext_sel_pin),
            .rom_on_pin  (rom_on_pin[c]),
            .rom_clr     (release_evt),
            .cpu_we      (cpu_we[c]),
            .cpu_wdata   (cpu_wdata[c*CTL_W +: CTL_W]),
            .ctl_q       (ctl_c)
        );

        assign ctl_reg[c*CTL_W +: CTL_W] = ctl_c;
        assign rom_mapped[c]             = ext_q & ctl_c[CTL_ROM_BIT];
        assign core_rst_n[c]             = released_q;
        assign boot_vec[c*PADDR_W +: PADDR_W] = BOOT_VEC;
        assign host_slave_en[c]          = !ext_q && (c == int'(sub_b_q));

        always_comb begin
            if (!ext_q)
                boot_src[2*c +: 2] = SRC_HOST_RAM;
            else if (rom_on_q[c])
                boot_src[2*c +: 2] = SRC_ROM;
            else
                boot_src[2*c +: 2] = SRC_EXT;
        end

        boot_region_dec #(
            .PADDR_W   (PADDR_W),
            .WIN_BASE  (WIN_BASE),
            .WIN_WORDS (WIN_WORDS)
        ) u_dec (
            .paddr      (core_paddr[c*PADDR_W +: PADDR_W]),
            .rom_mapped (ext_q & ctl_c[CTL_ROM_BIT]),
            .rom_sel    (rom_sel[c]),
            .ram_sel    (ram_sel[c])
        );
    end

endmodule

// File: rtl/boot_mode_ctrl_chk.sv
module boot_mode_ctrl_chk #(
    parameter int unsigned     N_CORES  = 2,
    parameter int unsigned     HA_W     = 16,
    parameter logic [HA_W-1:0] REL_ADDR = 16'h002F
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_mode,
    input logic               host_nomux,
    input logic [N_CORES-1:0] host_slave_en,
    input logic               host_we,
    input logic [HA_W-1:0]    host_addr,
    input logic [N_CORES-1:0] core_rst_n,
    input logic [N_CORES-1:0] rom_mapped,
    input logic [N_CORES-1:0] rom_sel,
    input logic               subsys_pin_oe,
    input logic               subsys_pin_o
);

    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(ext_mode) && $stable(host_nomux) && $stable(host_slave_en)));

    a_r2_host_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (rom_mapped == '0));

    a_r3_release_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ext_mode && $rose(|core_rst_n)) |->
        $past(host_we && (host_addr == REL_ADDR)));

    a_r4_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$fell(|core_rst_n));

    a_r7_rom_needs_map: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel & ~rom_mapped) == '0);

    a_r9_slave_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(host_slave_en));

    a_r10_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !subsys_pin_oe |-> !subsys_pin_o);

    for (genvar c = 0; c < N_CORES; c++) begin : g_chk
        a_r8_flag_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> !$rose(rom_mapped[c]));
    end

endmodule

bind boot_mode_ctrl boot_mode_ctrl_chk #(
    .N_CORES  (N_CORES),
    .HA_W     (HA_W),
    .REL_ADDR (REL_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_mode      (ext_mode),
    .host_nomux    (host_nomux),
    .host_slave_en (host_slave_en),
    .host_we       (host_we),
    .host_addr     (host_addr),
    .core_rst_n    (core_rst_n),
    .rom_mapped    (rom_mapped),
    .rom_sel       (rom_sel),
    .subsys_pin_oe (subsys_pin_oe),
    .subsys_pin_o  (subsys_pin_o)
);

// File: tb/tb_boot_mode_ctrl.sv
module tb_boot_mode_ctrl;

    localparam int N  = 2;
    localparam int PW = 19;
    localparam int HW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            ext_sel_pin = 1'b0, host_nomux_pin = 1'b0, subsys_pin_i = 1'b0;
    logic [N-1:0]    rom_on_pin = '0;
    logic            host_we = 1'b0;
    logic [HW-1:0]   host_addr = '0;
    logic [N-1:0]    cpu_we = '0;
    logic [N*8-1:0]  cpu_wdata = '0;
    logic [N*PW-1:0] core_paddr = '0;
    logic            ext_addr_msb = 1'b0;

    logic            ext_mode, host_nomux, subsys_pin_oe, subsys_pin_o;
    logic [N-1:0]    host_slave_en, core_rst_n, rom_mapped, rom_sel, ram_sel;
    logic [N*8-1:0]  ctl_reg;
    logic [N*2-1:0]  boot_src;
    logic [N*PW-1:0] boot_vec;

    boot_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_sel_pin(ext_sel_pin),
        .host_nomux_pin(host_nomux_pin), .subsys_pin_i(subsys_pin_i),
        .rom_on_pin(rom_on_pin), .host_we(host_we), .host_addr(host_addr),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .core_paddr(core_paddr),
        .ext_addr_msb(ext_addr_msb), .ext_mode(ext_mode), .host_nomux(host_nomux),
        .host_slave_en(host_slave_en), .core_rst_n(core_rst_n), .ctl_reg(ctl_reg),
        .rom_mapped(rom_mapped), .boot_src(boot_src), .boot_vec(boot_vec),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .subsys_pin_oe(subsys_pin_oe),
        .subsys_pin_o(subsys_pin_o)
    );

    typedef struct {
        string       req;
        int          sel;
        logic [63:0] exp;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    function automatic logic [63:0] obs(int sel);
        case (sel)
            0:  return 64'(core_rst_n);
            1:  return 64'(ctl_reg);
            2:  return 64'(rom_mapped);
            3:  return 64'(boot_src);
            4:  return 64'(rom_sel);
            5:  return 64'(ram_sel);
            6:  return 64'(host_slave_en);
            7:  return 64'(host_nomux);
            8:  return 64'(subsys_pin_oe);
            9:  return 64'(subsys_pin_o);
            10: return 64'(boot_vec);
            default: return 64'(ext_mode);
        endcase
    endfunction

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [63:0] got;
            it  = sb.pop_front();
            got = obs(it.sel);
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s (port %0d): actual=%0h expected=%0h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic expect_v(string req, int sel, logic [63:0] exp);
        sb.push_back('{req, sel, exp});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic host_wr(logic [HW-1:0] a);
        host_we = 1'b1; host_addr = a;
        step();
        host_we = 1'b0;
    endtask

    task automatic cpu_wr(int core, logic [7:0] d);
        cpu_we[core] = 1'b1; cpu_wdata[core*8 +: 8] = d;
        step();
        cpu_we = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---------- host-port mode ----------
        rst_n = 1'b0;
        ext_sel_pin = 1'b0; host_nomux_pin = 1'b1; subsys_pin_i = 1'b1; rom_on_pin = 2'b11;
        step(); step(); step();
        rst_n = 1'b1;
        expect_v("R2 cores held", 0, 64'h0);
        expect_v("R5 host reset value", 1, 64'h8080);
        expect_v("R2 no rom", 2, 64'h0);
        expect_v("R2 src ram", 3, 64'h0);
        expect_v("R9 slave B", 6, 64'h2);
        expect_v("R9 nomux", 7, 64'h1);
        expect_v("R10 pin input", 8, 64'h0);
        expect_v("R2 mode", 11, 64'h0);
        step();
        ext_sel_pin = 1'b1; subsys_pin_i = 1'b0; host_nomux_pin = 1'b0;
        step();
        expect_v("R1 mode held", 11, 64'h0);
        expect_v("R1 slave held", 6, 64'h2);
        expect_v("R1 nomux held", 7, 64'h1);
        core_paddr = {19'h0FFFF, 19'h0E000};
        #1;
        expect_v("R7 host window ram", 5, 64'h3);
        expect_v("R7 host window no rom", 4, 64'h0);
        host_wr(16'h002E);
        expect_v("R4 wrong addr rst", 0, 64'h0);
        expect_v("R4 wrong addr reg", 1, 64'h8080);
        host_wr(16'h002F);
        expect_v("R3 release", 0, 64'h3);
        expect_v("R3 flag clear", 1, 64'h0000);
        cpu_wr(0, 8'hFF);
        expect_v("R8 bit7 not set", 1, 64'h007F);
        host_wr(16'h002F);
        expect_v("R4 repeat reg", 1, 64'h007F);
        expect_v("R4 repeat rst", 0, 64'h3);

        // ---------- external-interface mode ----------
        rst_n = 1'b0;
        ext_sel_pin = 1'b0; host_nomux_pin = 1'b1; subsys_pin_i = 1'b1; rom_on_pin = 2'b01;
        step(); step();
        ext_sel_pin = 1'b1; host_nomux_pin = 1'b0; subsys_pin_i = 1'b0; rom_on_pin = 2'b10;
        step(); step();
        rst_n = 1'b1;
        expect_v("R6 first cycle held", 0, 64'h0);
        expect_v("R1 last-edge capture", 11, 64'h1);
        expect_v("R5 ext reset value", 1, 64'h8000);
        expect_v("R6 boot source", 3, 64'h6);
        expect_v("R6 boot vector", 10, {26'h0, 19'h0FF80, 19'h0FF80});
        expect_v("R7 map", 2, 64'h2);
        expect_v("R9 no slave", 6, 64'h0);
        expect_v("R10 pin driven", 8, 64'h1);
        step();
        expect_v("R6 run", 0, 64'h3);
        ext_addr_msb = 1'b1;
        #1;
        expect_v("R10 addr msb 1", 9, 64'h1);
        step();
        ext_addr_msb = 1'b0;
        #1;
        expect_v("R10 addr msb 0", 9, 64'h0);
        core_paddr = {19'h0FF80, 19'h0E000};
        #1;
        expect_v("R7 rom hit", 4, 64'h2);
        expect_v("R7 ram hit", 5, 64'h1);
        step();
        core_paddr = {19'h0DFFF, 19'h1E000};
        #1;
        expect_v("R7 outside rom", 4, 64'h0);
        expect_v("R7 outside ram", 5, 64'h0);
        host_wr(16'h002F);
        expect_v("R4 ext host ignored", 1, 64'h8000);
        cpu_wr(1, 8'h05);
        expect_v("R8 clear flag", 1, 64'h0500);
        expect_v("R8 unmapped", 2, 64'h0);
        expect_v("R6 source kept", 3, 64'h6);
        cpu_wr(1, 8'h80);
        expect_v("R8 no re-set", 1, 64'h0000);

        step(); step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule